// File: doc/BRIEF.md
# Reconfigurable Interleaved Serial Shift Memory

This block is a sequential-access bit store with no address input. Its storage is eight fixed shift segments, split into two halves of four. A static layout choice links the segments into one lane of 1024 bits, two lanes of 512 bits, or four lanes of 256 bits (sizes given for the default segment length of 128). A bit written into a lane comes out of that lane's serial output exactly one lane length of cycles later. Nothing can be read or written at an arbitrary position; data must be used as it streams past.

Every lane is built from two equal half-chains, one from each half. The two-phase clock is modelled as one system clock plus a phase bit that alternates every cycle. The first half-chain shifts on even cycles and the second on odd cycles. An output merger picks the half-chain that is moving in the current cycle, so the lane takes and delivers one bit per cycle. This is twice the rate of either half-chain alone.

Each lane has its own recirculate enable. When it is set, the lane's output is written back into the lane and the external data bit is not used, so the contents loop forever. The layout is captured only while reset is held. Reset also clears all storage to zero.

Top module: `interleaved_shift_mem`

## Requirements
- R1: While `rst_n` is low, every cell is cleared and `dout` is all zero. For the first lane-length cycles after reset is released, every lane output is 0.
- R2: `layout_sel` is captured only while `rst_n` is low. The codes are 2'b00 for one lane, 2'b01 for two lanes, and 2'b10 or 2'b11 for four lanes. A change to `layout_sel` after reset has no effect on lane lengths or lane count.
- R3: With layout 2'b00, lane 0 (`din[0]`/`dout[0]`) is 8*SEG_LEN long. The `dout[0]` value in cycle k equals the bit written into lane 0 in cycle k-8*SEG_LEN. Cycle 0 is the first cycle with `rst_n` high.
- R4: With layout 2'b01, lanes 0 and 1 are independent, each 4*SEG_LEN long. They follow the same write-to-read relation as R3.
- R5: With layout 2'b10 or 2'b11, lanes 0 to 3 are independent, each 2*SEG_LEN long. They follow the same relation.
- R6: A lane accepts and delivers one bit in every cycle. Even cycles move the first half-chain only and odd cycles move the second half-chain only. Bits in adjacent cycles therefore stay independent, even when they alternate.
- R7: When `recirc_en[l]` is 1, the bit written into lane l in that cycle is the lane's own `dout[l]`, and `din[l]` is ignored.
- R8: Lanes with an index not below the active lane count drive `dout` 0. Their `din` and `recirc_en` bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the phase bit toggles on each edge |
| rst_n | input | 1 | Synchronous active-low reset; layout is captured while low |
| layout_sel | input | 2 | Lane layout code (00: 1 lane, 01: 2 lanes, 1x: 4 lanes) |
| recirc_en | input | 4 | Per-lane loop-back enable |
| din | input | 4 | Per-lane serial data in |
| dout | output | 4 | Per-lane serial data out |

## Verification
The hardest situation to reach from the ports is a recirculated bit coming back out after a full second trip around the lane. Proving it needs a lane that was first loaded from outside, then set to loop back for a full lane length, and then watched for a further lane length. The stimulus runs each layout for four lane lengths. The first two lane lengths load and drain external patterns, including a strictly alternating one that separates the two half-chains. In the last two, the even lanes recirculate while their `din` carries contrary data, and `layout_sel` is moved away from the captured code without a reset.

// File: rtl/srm_pkg.sv
// Shared types and helpers for the interleaved shift memory.
// Assumes a fixed organisation of two halves with four segments each.
package srm_pkg;

    localparam int SEGS_PER_HALF = 4;
    localparam int LANE_MAX      = SEGS_PER_HALF;
    localparam int SEG_IDX_W     = $clog2(SEGS_PER_HALF);

    typedef enum logic [1:0] {
        LAYOUT_SINGLE   = 2'b00,
        LAYOUT_DUAL     = 2'b01,
        LAYOUT_QUAD     = 2'b10,
        LAYOUT_QUAD_ALT = 2'b11
    } layout_e;

    // log2 of the number of segments one lane uses inside one half
    function automatic int span_log2(layout_e lay);
        case (lay)
            LAYOUT_SINGLE: return SEG_IDX_W;
            LAYOUT_DUAL:   return SEG_IDX_W - 1;
            default:       return 0;
        endcase
    endfunction

    // number of lanes active in a given layout
    function automatic int lane_count(layout_e lay);
        return SEGS_PER_HALF >> span_log2(lay);
    endfunction

endpackage

// File: rtl/srm_segment.sv
// One fixed shift segment of SEG_LEN cells.
// Shifts by one cell when shift_en is high. bit_out is the oldest cell.
// Assumes SEG_LEN >= 2 and that shift_en is already low during reset.
module srm_segment #(
    parameter int SEG_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic bit_out
);

    logic [SEG_LEN-1:0] cells;

    // clear on reset, otherwise advance one cell per enabled tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cells <= '0;
        else if (shift_en)
            cells <= {cells[SEG_LEN-2:0], bit_in};
    end

    // the oldest cell leaves the segment
    assign bit_out = cells[SEG_LEN-1];

    // R1
    seg_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cells == '0));

    // R6
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !shift_en) |=> $stable(cells));

    // R6
    seg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cells[0] == $past(bit_in)));

endmodule

// File: rtl/srm_half.sv
// One half of the store: four segments that move together on one phase.
// The layout decides how the segments are linked: as one chain of four,
// two chains of two, or four single-segment chains. lane_tail[l] is the
// last cell of lane l's chain in this half (0 for lanes that do not exist).
module srm_half import srm_pkg::*; #(
    parameter int SEG_LEN = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  layout_e             layout,
    input  logic [LANE_MAX-1:0] lane_in,
    output logic [LANE_MAX-1:0] lane_tail
);

    logic [SEGS_PER_HALF-1:0] seg_in;
    logic [SEGS_PER_HALF-1:0] seg_tail;
    logic [SEG_IDX_W-1:0]     span_mask;
    int                       lg;

    // segments per lane chain, as a shift amount and as a low-bit mask
    always_comb begin
        lg        = span_log2(layout);
        span_mask = ~({SEG_IDX_W{1'b1}} << lg);
    end

    for (genvar j = 0; j < SEGS_PER_HALF; j++) begin : g_seg
        localparam logic [SEG_IDX_W-1:0] JV = SEG_IDX_W'(j);

        if (j == 0) begin : g_head
            // segment 0 always heads lane 0
            always_comb seg_in[j] = lane_in[0];
        end else begin : g_link
            // head of a lane takes the lane input, otherwise the previous tail
            always_comb begin
                if ((JV & span_mask) == '0)
                    seg_in[j] = lane_in[JV >> lg];
                else
                    seg_in[j] = seg_tail[j-1];
            end
        end

        srm_segment #(.SEG_LEN(SEG_LEN)) u_seg (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .bit_in   (seg_in[j]),
            .bit_out  (seg_tail[j])
        );
    end

    // pick the last segment of each lane chain
    always_comb begin
        for (int l = 0; l < LANE_MAX; l++) begin
            int last;
            last = ((l + 1) << lg) - 1;
            if (last < SEGS_PER_HALF)
                lane_tail[l] = seg_tail[last[SEG_IDX_W-1:0]];
            else
                lane_tail[l] = 1'b0;
        end
    end

endmodule

// File: rtl/srm_merge.sv
// Output merger and input steering.
// For each active lane it shows the tail of the half that moves in this
// cycle, and picks the write bit from din or from the lane's own output.
// Inactive lanes are forced to 0 on both sides.
module srm_merge import srm_pkg::*; (
    input  logic                phase,
    input  layout_e             layout,
    input  logic [LANE_MAX-1:0] tail_a,
    input  logic [LANE_MAX-1:0] tail_b,
    input  logic [LANE_MAX-1:0] recirc_en,
    input  logic [LANE_MAX-1:0] din,
    output logic [LANE_MAX-1:0] dout,
    output logic [LANE_MAX-1:0] lane_in
);

    int n_active;

    // number of lanes the current layout provides
    always_comb n_active = lane_count(layout);

    // interleave the two halves and route each lane's write bit
    always_comb begin
        for (int l = 0; l < LANE_MAX; l++) begin
            if (l < n_active) begin
                dout[l]    = phase ? tail_b[l] : tail_a[l];
                lane_in[l] = recirc_en[l] ? dout[l] : din[l];
            end else begin
                dout[l]    = 1'b0;
                lane_in[l] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/interleaved_shift_mem.sv
// Reconfigurable interleaved serial shift memory, top level.
// Two halves of four segments move on opposite phases. The phase bit
// toggles every cycle after reset and starts on the first half. The layout
// is latched only while the synchronous active-low reset is held.
module interleaved_shift_mem import srm_pkg::*; #(
    parameter int SEG_LEN = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          layout_sel,
    input  logic [LANE_MAX-1:0] recirc_en,
    input  logic [LANE_MAX-1:0] din,
    output logic [LANE_MAX-1:0] dout
);

    layout_e             layout_q;
    logic                phase;
    logic                en_a;
    logic                en_b;
    logic [LANE_MAX-1:0] tail_a;
    logic [LANE_MAX-1:0] tail_b;
    logic [LANE_MAX-1:0] lane_in;

    // capture the layout only during reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            layout_q <= layout_e'(layout_sel);
    end

    // phase bit: first half on even ticks, second half on odd ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= 1'b0;
        else
            phase <= ~phase;
    end

    // per-half shift enables, held off during reset
    always_comb begin
        en_a = rst_n & ~phase;
        en_b = rst_n &  phase;
    end

    srm_half #(.SEG_LEN(SEG_LEN)) u_half_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (en_a),
        .layout    (layout_q),
        .lane_in   (lane_in),
        .lane_tail (tail_a)
    );

    srm_half #(.SEG_LEN(SEG_LEN)) u_half_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (en_b),
        .layout    (layout_q),
        .lane_in   (lane_in),
        .lane_tail (tail_b)
    );

    srm_merge u_merge (
        .phase     (phase),
        .layout    (layout_q),
        .tail_a    (tail_a),
        .tail_b    (tail_b),
        .recirc_en (recirc_en),
        .din       (din),
        .dout      (dout),
        .lane_in   (lane_in)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

    // R2
    layout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(layout_q));

    // R6
    phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase != $past(phase)));

    // R8
    single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (layout_q == LAYOUT_SINGLE) |-> (dout[LANE_MAX-1:1] == '0));

    // R8
    dual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (layout_q == LAYOUT_DUAL) |-> (dout[LANE_MAX-1:2] == '0));

endmodule

// File: tb/sim_interleaved_shift_mem.sv
module sim_interleaved_shift_mem;

    localparam int SEG   = 128;
    localparam int TOTAL = 8 * SEG;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] layout_sel = 2'b00;
    logic [3:0] recirc_en = 4'h0;
    logic [3:0] din = 4'h0;
    logic [3:0] dout;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    bit [3:0] hist [0:4095];

    always #10 clk = ~clk;

    interleaved_shift_mem #(.SEG_LEN(SEG)) u0 (
        .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel),
        .recirc_en(recirc_en), .din(din), .dout(dout)
    );

    task automatic check_bit(input logic got, input logic exp, input string tag,
                             input int k, input int l);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s lane %0d cycle %0d: got %b expected %b", tag, l, k, got, exp);
        end
    endtask

    task automatic run_layout(input logic [1:0] code);
        int nl;
        int len;
        string mtag;
        nl   = (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
        len  = TOTAL / nl;
        mtag = (nl == 1) ? "R3" : (nl == 2) ? "R4" : "R5";

        // reset with the wanted layout and busy inputs
        @(negedge clk);
        rst_n = 1'b0; layout_sel = code; din = 4'hF; recirc_en = 4'h0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            checks++;
            if (dout !== 4'h0) begin
                failures++;
                $display("FAIL R1 during reset: got %b expected 0000", dout);
            end
        end
        rst_n = 1'b1;

        for (int k = 0; k < 4 * len; k++) begin
            logic [3:0] nd;
            logic [3:0] nr;
            if (k == len) layout_sel = code ^ 2'b01; // R2: change without reset
            for (int l = 0; l < 4; l++) begin
                logic  e;
                logic  pa;
                string tag;
                e = (l < nl && k >= len) ? hist[k-len][l] : 1'b0;
                if (l >= nl)          tag = "R8";
                else if (k < len)     tag = "R1";
                else if (k < 2 * len) tag = {mtag, " R6"};
                else if (l % 2 == 0)  tag = "R2 R7";
                else                  tag = {"R2 ", mtag};
                check_bit(dout[l], e, tag, k, l);

                pa = 1'(((k * 5 + l * 3) >> 1) ^ (k >> 4) ^ (k >> 7));
                if (k < len) begin
                    nd[l] = pa; nr[l] = (l >= nl) ? 1'b1 : 1'b0;
                end else if (k < 2 * len) begin
                    nd[l] = 1'((k + l) & 1); nr[l] = 1'b0;  // strict alternation
                end else begin
                    nd[l] = ~pa; nr[l] = (l % 2 == 0) ? 1'b1 : 1'(k & 1);
                    if (l < nl && l % 2 != 0) nr[l] = 1'b0;
                end
                hist[k][l] = nr[l] ? e : nd[l];
            end
            din = nd; recirc_en = nr;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        run_layout(2'b00);
        run_layout(2'b01);
        run_layout(2'b10);
        run_layout(2'b11);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule